// File: doc/BRIEF.md
# Quad-Port Reset Strap Decoder

This block turns a handful of board-level strap pins into a fixed configuration for each of the four ports of an Ethernet transceiver. The straps are sampled once, on the first rising clock edge after synchronous reset is released. From that captured snapshot the block derives, per port, a 5-bit management address, an 11-bit scrambler seed, a scrambler enable, an auto-negotiation enable, a forced-speed value, a fiber-mode flag and a transmit transformer-ratio select.

The upper three address bits are common to all ports. The two lower bits come from the port index, rotated by one position or not, depending on a rotation strap. Each port's scrambler seed is built from its own address, so ports that start transmitting together use different seeds. The auto-negotiation strap takes precedence over the speed-force strap. A fiber-disable strap, when low, moves only the last port into 100 Mb/s fiber operation. While reset is held, and until the capture edge, every port shows a safe default configuration. After capture the outputs stay frozen until reset is asserted again.

Top module: `qport_strap_decoder`

## Requirements
- R1: The straps are captured on the first rising edge of `clk` at which `rst` is low after reset. Strap changes after that edge have no effect on any output until `rst` is asserted again.
- R2: While `rst` is high, and after release until the capture edge, every port shows its defaults: address 0, seed 11'h5A3, `port_scr_en`=1, `port_aneg_en`=1, `port_spd100`=1, `port_fiber`=0, `port_xfmr_125`=0.
- R3: After capture, address bits [4:2] of every port equal the captured `strap_addr_hi`.
- R4: With `strap_rot`=1 captured, address bits [1:0] of port n equal n.
- R5: With `strap_rot`=0 captured, address bits [1:0] of port n equal (n+1) mod 4, so port 3 gets 00.
- R6: With `strap_aneg`=1 captured, every copper port has `port_aneg_en`=1 and `port_spd100`=1, whatever the level of `strap_force100`.
- R7: With `strap_aneg`=0 captured, every copper port has `port_aneg_en`=0, and `port_spd100` equals the captured `strap_force100` (1 = 100 Mb/s, 0 = 10 Mb/s).
- R8: After capture, `port_scr_en` of every port equals the captured `strap_scr` (0 = scrambler bypassed).
- R9: With `strap_fx_dis` low captured, port 3 alone has `port_fiber`=1, `port_aneg_en`=0 and `port_spd100`=1. Ports 0 to 2 keep their copper decode. With `strap_fx_dis` high, no port is fiber.
- R10: After capture, `port_xfmr_125` of every port is the inverse of the captured `strap_xfmr` (1 selects the 1.25:1 ratio, 0 selects 1:1).
- R11: Each port's seed equals 11'h5A3 XOR its zero-extended 5-bit address. The seed is never zero, and the seeds of the four ports differ from one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_addr_hi | input | 3 | Shared upper address bits [4:2] |
| strap_rot | input | 1 | Low-address rotation select (1 = port n gets n) |
| strap_aneg | input | 1 | Auto-negotiation enable strap |
| strap_force100 | input | 1 | Forced speed when auto-negotiation is off (1 = 100 Mb/s) |
| strap_scr | input | 1 | Scrambler enable strap |
| strap_fx_dis | input | 1 | Fiber disable strap, low puts port 3 in fiber mode |
| strap_xfmr | input | 1 | Transformer strap, low selects 1.25:1 |
| port_addr | output | 20 | Per-port address, port n at bits [5n+4:5n] |
| port_seed | output | 44 | Per-port scrambler seed, port n at bits [11n+10:11n] |
| port_scr_en | output | 4 | Per-port scrambler enable |
| port_aneg_en | output | 4 | Per-port auto-negotiation enable |
| port_spd100 | output | 4 | Per-port speed, 1 = 100 Mb/s |
| port_fiber | output | 4 | Per-port fiber mode |
| port_xfmr_125 | output | 4 | Per-port 1.25:1 transformer select |

## Verification
A wrong capture state shows up as an output that still follows the live straps after the capture edge, or as non-default outputs in the cycle between reset release and capture. Both are visible within one clock. A wrong address rotation or seed derivation appears on `port_addr` and `port_seed` in the first cycle after capture, as duplicated or shifted port addresses. A wrong precedence between the auto-negotiation and force straps, or a fiber flag on the wrong port, shows up at once on `port_aneg_en`, `port_spd100` and `port_fiber` for the affected strap combination. The bench therefore sweeps all of those combinations, then flips the straps after capture and checks that every output stays unchanged.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int NPORTS     = 4;
  localparam int ADDR_W     = 5;
  localparam int LOW_W      = $clog2(NPORTS);
  localparam int HI_W       = ADDR_W - LOW_W;
  localparam int SEED_W     = 11;
  localparam logic [SEED_W-1:0] SEED_BASE = 11'h5A3;
  localparam int FIBER_PORT = NPORTS - 1;

  typedef struct packed {
    logic [HI_W-1:0] addr_hi;
    logic            rot;
    logic            aneg;
    logic            force100;
    logic            scr;
    logic            fx_dis;
    logic            xfmr;
  } strap_t;

  // Low address bits of a port: identity or rotated up by one, modulo NPORTS.
  function automatic logic [LOW_W-1:0] rot_low(input int unsigned idx, input logic rot);
    int unsigned v;
    v = rot ? idx : idx + 1;
    return LOW_W'(v % NPORTS);
  endfunction

  // Seed: address folded into a constant whose upper bits are nonzero.
  function automatic logic [SEED_W-1:0] seed_of(input logic [ADDR_W-1:0] a);
    return SEED_BASE ^ SEED_W'(a);
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import strap_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  strap_t raw,
  output strap_t cap,
  output logic   live,
  output logic   cap_fire
);
  // One capture per reset: the first edge with rst low while not yet live.
  assign cap_fire = !rst && !live;

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= 1'b0;
      cap  <= '0;
    end else if (cap_fire) begin
      live <= 1'b1;
      cap  <= raw;
    end
  end
endmodule

// File: rtl/port_cfg_decode.sv
module port_cfg_decode
  import strap_pkg::*;
#(
  parameter int PORT_IDX = 0
) (
  input  logic              rst,
  input  logic              live,
  input  strap_t            cap,
  output logic [ADDR_W-1:0] addr,
  output logic [SEED_W-1:0] seed,
  output logic              scr_en,
  output logic              aneg_en,
  output logic              spd100,
  output logic              fiber,
  output logic              xfmr_125
);
  localparam bit IS_FIBER_CAPABLE = (PORT_IDX == FIBER_PORT);

  logic fiber_sel;
  assign fiber_sel = IS_FIBER_CAPABLE && !cap.fx_dis;

  always_comb begin
    if (rst || !live) begin
      addr     = '0;
      scr_en   = 1'b1;
      aneg_en  = 1'b1;
      spd100   = 1'b1;
      fiber    = 1'b0;
      xfmr_125 = 1'b0;
    end else begin
      addr     = {cap.addr_hi, rot_low(PORT_IDX, cap.rot)};
      scr_en   = cap.scr;
      fiber    = fiber_sel;
      // fiber mode has no negotiation; otherwise aneg strap wins over force
      aneg_en  = cap.aneg && !fiber_sel;
      spd100   = fiber_sel || cap.aneg || cap.force100;
      xfmr_125 = !cap.xfmr;
    end
  end

  assign seed = seed_of(addr);
endmodule

// File: rtl/qport_strap_decoder.sv
module qport_strap_decoder
  import strap_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               strap_addr_hi,
  input  logic                     strap_rot,
  input  logic                     strap_aneg,
  input  logic                     strap_force100,
  input  logic                     strap_scr,
  input  logic                     strap_fx_dis,
  input  logic                     strap_xfmr,
  output logic [NPORTS*ADDR_W-1:0] port_addr,
  output logic [NPORTS*SEED_W-1:0] port_seed,
  output logic [NPORTS-1:0]        port_scr_en,
  output logic [NPORTS-1:0]        port_aneg_en,
  output logic [NPORTS-1:0]        port_spd100,
  output logic [NPORTS-1:0]        port_fiber,
  output logic [NPORTS-1:0]        port_xfmr_125
);
  strap_t raw_straps;
  strap_t cap_straps;
  logic   cfg_live;
  logic   cap_fire;

  assign raw_straps = '{addr_hi:  strap_addr_hi,
                        rot:      strap_rot,
                        aneg:     strap_aneg,
                        force100: strap_force100,
                        scr:      strap_scr,
                        fx_dis:   strap_fx_dis,
                        xfmr:     strap_xfmr};

  strap_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .raw      (raw_straps),
    .cap      (cap_straps),
    .live     (cfg_live),
    .cap_fire (cap_fire)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    port_cfg_decode #(.PORT_IDX(p)) u_dec (
      .rst      (rst),
      .live     (cfg_live),
      .cap      (cap_straps),
      .addr     (port_addr[p*ADDR_W +: ADDR_W]),
      .seed     (port_seed[p*SEED_W +: SEED_W]),
      .scr_en   (port_scr_en[p]),
      .aneg_en  (port_aneg_en[p]),
      .spd100   (port_spd100[p]),
      .fiber    (port_fiber[p]),
      .xfmr_125 (port_xfmr_125[p])
    );
  end
endmodule

// File: rtl/qport_strap_checker.sv
module qport_strap_checker
  import strap_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic                     cfg_live,
  input logic                     cap_fire,
  input logic [NPORTS*ADDR_W-1:0] port_addr,
  input logic [NPORTS*SEED_W-1:0] port_seed,
  input logic [NPORTS-1:0]        port_scr_en,
  input logic [NPORTS-1:0]        port_aneg_en,
  input logic [NPORTS-1:0]        port_spd100,
  input logic [NPORTS-1:0]        port_fiber,
  input logic [NPORTS-1:0]        port_xfmr_125
);
  // R1: a capture edge makes the configuration live
  a_r1_capture_goes_live: assert property (@(posedge clk) disable iff (rst)
    cap_fire |=> cfg_live);

  // R1: once live, nothing moves until reset
  a_r1_frozen: assert property (@(posedge clk) disable iff (rst)
    (cfg_live && $past(cfg_live)) |->
      ($stable(port_addr) && $stable(port_seed) && $stable(port_scr_en) &&
       $stable(port_aneg_en) && $stable(port_spd100) && $stable(port_fiber) &&
       $stable(port_xfmr_125)));

  // R2: defaults in reset and before capture
  always @(negedge clk) begin
    if (rst === 1'b1 || cfg_live === 1'b0) begin
      a_r2_defaults: assert (port_addr == '0 && port_scr_en == '1 &&
                             port_aneg_en == '1 && port_spd100 == '1 &&
                             port_fiber == '0 && port_xfmr_125 == '0);
    end
  end

  // R9: only the last port may be fiber, and fiber never negotiates
  a_r9_fiber_last_only: assert property (@(posedge clk) disable iff (rst)
    port_fiber[NPORTS-2:0] == '0);
  a_r9_fiber_no_aneg: assert property (@(posedge clk) disable iff (rst)
    port_fiber[FIBER_PORT] |-> (!port_aneg_en[FIBER_PORT] && port_spd100[FIBER_PORT]));

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    // R3: upper bits shared across ports
    a_r3_hi_shared: assert property (@(posedge clk) disable iff (rst)
      port_addr[p*ADDR_W+LOW_W +: HI_W] == port_addr[LOW_W +: HI_W]);
    // R11: seed never zero
    a_r11_seed_nonzero: assert property (@(posedge clk) disable iff (rst)
      port_seed[p*SEED_W +: SEED_W] != '0);
    // R6: negotiating ports advertise full speed
    a_r6_aneg_full_speed: assert property (@(posedge clk) disable iff (rst)
      port_aneg_en[p] |-> port_spd100[p]);
    // R8/R10: shared straps give the same value on every port
    a_r8_scr_uniform: assert property (@(posedge clk) disable iff (rst)
      port_scr_en[p] == port_scr_en[0]);
    a_r10_xfmr_uniform: assert property (@(posedge clk) disable iff (rst)
      port_xfmr_125[p] == port_xfmr_125[0]);
    for (genvar q = p + 1; q < NPORTS; q++) begin : g_pair
      // R4/R5: rotation keeps addresses distinct once live
      a_r5_addr_distinct: assert property (@(posedge clk) disable iff (rst)
        cfg_live |-> (port_addr[p*ADDR_W +: ADDR_W] != port_addr[q*ADDR_W +: ADDR_W]));
      // R11: seeds distinct once live
      a_r11_seed_distinct: assert property (@(posedge clk) disable iff (rst)
        cfg_live |-> (port_seed[p*SEED_W +: SEED_W] != port_seed[q*SEED_W +: SEED_W]));
    end
  end
endmodule

bind qport_strap_decoder qport_strap_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_live      (cfg_live),
  .cap_fire      (cap_fire),
  .port_addr     (port_addr),
  .port_seed     (port_seed),
  .port_scr_en   (port_scr_en),
  .port_aneg_en  (port_aneg_en),
  .port_spd100   (port_spd100),
  .port_fiber    (port_fiber),
  .port_xfmr_125 (port_xfmr_125)
);

// File: tb/sim_qport_strap_decoder.sv
`timescale 1ns/1ps
module sim_qport_strap_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  strap_addr_hi = '0;
  logic        strap_rot = 1'b0, strap_aneg = 1'b0, strap_force100 = 1'b0;
  logic        strap_scr = 1'b0, strap_fx_dis = 1'b1, strap_xfmr = 1'b1;
  logic [19:0] port_addr;
  logic [43:0] port_seed;
  logic [3:0]  port_scr_en, port_aneg_en, port_spd100, port_fiber, port_xfmr_125;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  qport_strap_decoder u0 (.*);

  // vector fields: {addr_hi[2:0], rot, aneg, force100, scr, fx_dis, xfmr}
  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    9'b101_1_1_0_1_1_1,
    9'b101_0_1_1_1_1_0,
    9'b011_1_0_1_0_1_1,
    9'b011_0_0_0_1_1_0,
    9'b000_1_0_1_1_0_1,
    9'b111_0_1_0_0_0_0,
    9'b110_0_0_0_0_0_1,
    9'b001_1_1_1_1_1_1
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] v);
    {strap_addr_hi, strap_rot, strap_aneg, strap_force100,
     strap_scr, strap_fx_dis, strap_xfmr} = v;
  endtask

  task automatic check_defaults(input string req);
    chk(req, 64'(port_addr), 64'h0);
    for (int p = 0; p < 4; p++) chk(req, 64'(port_seed[p*11 +: 11]), 64'h5A3);
    chk(req, 64'(port_scr_en), 64'hF);
    chk(req, 64'(port_aneg_en), 64'hF);
    chk(req, 64'(port_spd100), 64'hF);
    chk(req, 64'(port_fiber), 64'h0);
    chk(req, 64'(port_xfmr_125), 64'h0);
  endtask

  task automatic check_vec(input logic [8:0] v);
    logic [2:0] hi;
    logic rot, an, frc, scr, fxd, xf;
    {hi, rot, an, frc, scr, fxd, xf} = v;
    for (int p = 0; p < 4; p++) begin
      logic [1:0] lo;
      logic [4:0] a;
      logic fib;
      if (rot) lo = 2'(p);
      else     lo = (p == 3) ? 2'd0 : 2'(p + 1);
      a = {hi, lo};
      fib = (p == 3) && !fxd;
      chk(rot ? "R3/R4 addr" : "R3/R5 addr", 64'(port_addr[p*5 +: 5]), 64'(a));
      chk("R11 seed", 64'(port_seed[p*11 +: 11]), 64'(11'h5A3 ^ {6'd0, a}));
      chk("R9 fiber", 64'(port_fiber[p]), 64'(fib));
      chk(fib ? "R9 aneg" : (an ? "R6 aneg" : "R7 aneg"),
          64'(port_aneg_en[p]), 64'(fib ? 1'b0 : an));
      chk(fib ? "R9 speed" : (an ? "R6 speed" : "R7 speed"),
          64'(port_spd100[p]), 64'(fib ? 1'b1 : (an ? 1'b1 : frc)));
      chk("R8 scr", 64'(port_scr_en[p]), 64'(scr));
      chk("R10 xfmr", 64'(port_xfmr_125[p]), 64'(!xf));
    end
  endtask

  // reset with straps v, release, check pre-capture defaults, then decoded
  task automatic reset_capture(input logic [8:0] v);
    @(negedge clk);
    rst = 1'b1;
    drive(v);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check_defaults("R2 before capture");
    @(negedge clk);
    check_vec(v);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check_defaults("R2 in reset");

    for (int i = 0; i < NV; i++) reset_capture(VEC[i]);

    // R1: straps moving after capture change nothing
    reset_capture(VEC[0]);
    drive(~VEC[0]);
    repeat (4) @(negedge clk);
    check_vec(VEC[0]);
    drive(VEC[5]);
    @(negedge clk);
    check_vec(VEC[0]);

    // R1: new reset picks up the new straps
    reset_capture(VEC[5]);

    // R2: reasserting reset restores defaults immediately
    @(negedge clk);
    rst = 1'b1;
    #1;
    check_defaults("R2 reassert");
    @(negedge clk);
    check_defaults("R2 held");

    // R11: seeds pairwise distinct for both rotations
    for (int r = 0; r < 2; r++) begin
      reset_capture(r == 0 ? 9'b111_0_0_0_1_1_1 : 9'b111_1_0_0_1_1_1);
      for (int p = 0; p < 4; p++)
        for (int q = p + 1; q < 4; q++)
          chk("R11 seeds distinct",
              64'(port_seed[p*11 +: 11] != port_seed[q*11 +: 11]), 64'd1);
    end

    // R6 vs R7: aneg high hides force strap for both force levels
    reset_capture(9'b010_1_1_0_1_1_1);
    reset_capture(9'b010_1_1_1_1_1_1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200us;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule